// File: doc/BRIEF.md
# Code-Selected Reference Divider

This block divides a reference oscillator clock by one of eight fixed moduli and emits a pulse one clock wide at the divided rate. The pulse is the reference edge for a phase detector further down the loop. A 3-bit select code chooses the modulus through a small decode table. Seven of the table values are powers of two. One value, 2410, is not, so the divider is a true terminal-count counter and not a tap on a binary chain.

The counter is 14 bits wide, which covers the largest modulus of 8192. The modulus is captured at reset and again at every terminal count. A change of the select code in the middle of a period therefore never shortens or stretches the period that is running. The new value governs the next full period. An all-ones code, which is what floating select inputs read as, picks 8192.

Top module: `refdiv_top`

## Requirements
- R1: The select code `sel_code` (bit 2 most significant) maps to the modulus N as follows: 0→8, 1→128, 2→256, 3→512, 4→1024, 5→2048, 6→2410, 7→8192.
- R2: Every pulse on `ref_pulse_o` is high for exactly one clock cycle.
- R3: After reset is released, the first pulse appears N clock edges later. Each following pulse appears N edges after the previous one.
- R4: A code change between pulses leaves the running period at its old length. The period that starts at the next pulse uses the code sampled at that pulse's edge.
- R5: While `rst` is high, and on the cycle after it, `ref_pulse_o` is low. A reset in mid-period restarts the count from zero.
- R6: Code 6 divides by 2410 exactly, a modulus that is not a power of two.
- R7: The all-ones code divides by 8192. No pulse-to-pulse spacing ever exceeds 8192 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_code | input | 3 | Modulus select code |
| ref_pulse_o | output | 1 | Divided reference pulse, one cycle wide |

## Verification
A wrong table entry or a wrong terminal compare shows up as a wrong pulse spacing. The first pulse after reset arrives at least one cycle early or late, so the error is visible within one period of the selected modulus. A modulus register that does not hold through a period shows up in the period that contains the code change, and not one period later. The bench sweeps all eight codes and measures both the first spacing after reset and a steady-state spacing for each. It also changes the code in mid-period and resets just before a terminal count.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int CODE_W    = 3;
    localparam int CNT_W     = 14;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int MAX_MOD   = 8192;
    localparam int GAP_W     = CNT_W + 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  count_t;

    typedef struct packed {
        count_t cnt;
        count_t term;
        logic   pulse;
    } div_state_t;

    function automatic count_t modulus_of(input code_t c);
        count_t m;
        case (c)
            3'd0:    m = count_t'(8);
            3'd1:    m = count_t'(128);
            3'd2:    m = count_t'(256);
            3'd3:    m = count_t'(512);
            3'd4:    m = count_t'(1024);
            3'd5:    m = count_t'(2048);
            3'd6:    m = count_t'(2410);
            default: m = count_t'(MAX_MOD);
        endcase
        return m;
    endfunction

    function automatic count_t terminal_of(input code_t c);
        return count_t'(modulus_of(c) - count_t'(1));
    endfunction

endpackage

// File: rtl/refdiv_modsel.sv
module refdiv_modsel
    import refdiv_pkg::*;
(
    input  code_t  code_i,
    output count_t term_o
);
    always_comb begin
        term_o = terminal_of(code_i);
    end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  count_t term_i,
    output logic   pulse_o
);
    div_state_t st_q;
    div_state_t st_d;
    logic       at_term;

    assign at_term = (st_q.cnt == st_q.term);

    always_comb begin
        st_d = st_q;
        if (at_term) begin
            st_d.cnt   = '0;
            st_d.term  = term_i;
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt   = count_t'(st_q.cnt + count_t'(1));
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= '0;
            st_q.term  <= term_i;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
(
    input  logic              clk_ref,
    input  logic              rst,
    input  logic [CODE_W-1:0] sel_code,
    output logic              ref_pulse_o
);
    count_t term_sel;

    refdiv_modsel u_modsel (
        .code_i (code_t'(sel_code)),
        .term_o (term_sel)
    );

    refdiv_counter u_counter (
        .clk     (clk_ref),
        .rst     (rst),
        .term_i  (term_sel),
        .pulse_o (ref_pulse_o)
    );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
    import refdiv_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic pulse
);
    logic [GAP_W-1:0] gap_q;
    logic             rst_d = 1'b0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)        gap_q <= '0;
        else if (pulse) gap_q <= GAP_W'(1);
        else            gap_q <= GAP_W'(gap_q + GAP_W'(1));
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) pulse |=> !pulse); // R2
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst) pulse |-> (gap_q >= GAP_W'(8))); // R3
    AST_GAP_MAX: assert property (@(posedge clk) disable iff (rst) gap_q <= GAP_W'(MAX_MOD)); // R7

    always @(negedge clk) begin
        if (rst_d) begin
            AST_RESET_QUIET: assert (!pulse); // R5
        end
    end
endmodule

bind refdiv_top refdiv_chk u_chk (
    .clk   (clk_ref),
    .rst   (rst),
    .pulse (ref_pulse_o)
);

// File: tb/refdiv_top_tb.sv
module refdiv_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] code = 3'd7;
    logic       pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    refdiv_top u_dut (
        .clk_ref     (clk),
        .rst         (rst),
        .sel_code    (code),
        .ref_pulse_o (pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int expected_mod(input int c);
        int m;
        if (c == 6) m = 2410;
        else if (c == 0) m = 8;
        else m = 1 << (c + 6);
        return m;
    endfunction

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 200000", cycles);
            finish_sim();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // counts edges until the pulse is seen high at a negedge
    task automatic wait_pulse(output int k);
        k = 0;
        do begin
            tick();
            k++;
        end while (!pulse && k < LIMIT);
    endtask

    task automatic do_reset(input logic [2:0] c);
        code = c;
        rst  = 1'b1;
        tick();
        check(pulse == 1'b0, "R5 reset low", int'(pulse), 0);
        tick();
        rst = 1'b0;
    endtask

    // width check plus remaining spacing; returns full spacing
    task automatic next_gap(input string tag, output int gap);
        int k;
        tick();
        check(pulse == 1'b0, {tag, " R2 width"}, int'(pulse), 0);
        wait_pulse(k);
        gap = k + 1;
    endtask

    initial begin
        int k;
        int g;
        int n;
        @(negedge clk);
        // R1 R3 R6 R7 sweep over all codes
        for (int c = 0; c < 8; c++) begin
            n = expected_mod(c);
            do_reset(3'(c));
            wait_pulse(k);
            check(k == n, $sformatf("R1 R3 code %0d first spacing", c), k, n);
            next_gap("R3", g);
            if (c == 6)
                check(g == 2410, "R6 spacing code 6", g, 2410);
            else if (c == 7)
                check(g == 8192, "R7 spacing all-ones", g, 8192);
            else
                check(g == n, $sformatf("R1 code %0d period", c), g, n);
        end

        // R4: change in the middle of a short period
        do_reset(3'd0);
        tick(); tick(); tick();
        code = 3'd1;
        wait_pulse(k);
        check(k + 3 == 8, "R4 old period kept", k + 3, 8);
        next_gap("R4", g);
        check(g == 128, "R4 new period applied", g, 128);
        // R4: change again mid-period of the 128 period
        repeat (50) tick();
        code = 3'd2;
        wait_pulse(k);
        check(k + 50 == 128, "R4 second old period", k + 50, 128);
        next_gap("R4", g);
        check(g == 256, "R4 second new period", g, 256);

        // R5: reset one edge before terminal count
        do_reset(3'd0);
        repeat (7) tick();
        check(pulse == 1'b0, "R5 before terminal", int'(pulse), 0);
        rst = 1'b1;
        tick();
        check(pulse == 1'b0, "R5 pulse suppressed", int'(pulse), 0);
        rst = 1'b0;
        tick();
        check(pulse == 1'b0, "R5 cycle after reset", int'(pulse), 0);
        wait_pulse(k);
        check(k + 1 == 8, "R5 count restarted", k + 1, 8);

        finish_sim();
    end
endmodule